// File: doc/BRIEF.md
# Supply Rail Sequencing Controller

This controller decides, from digitised status flags, when three gate-drive enables may switch on and off. The enables are for a high rail, a mid rail and a low (core) rail. A READY output reports that the high rail has stayed above its undervoltage threshold for an unbroken stability period. The high-rail gate enable follows READY after a programmable turn-on delay. The mid and low enables are sequenced so that the low rail comes on first and goes off last.

The sequence is started and stopped by edges on a request input. A build-time parameter picks one of two modes. In time mode the mid rail follows the low rail after a fixed up-delay. In voltage mode the mid rail follows once a comparator flag reports that the low-rail feedback has passed its reference. In both modes, power-down turns the mid rail off first and the low rail off a down-delay later. Any fault drops the mid and low enables to an all-off idle state. This happens when READY or either rail flag falls. A fresh rising request edge is then needed before sequencing starts again. All delays are counted in clock cycles.

Top module: `rail_seq_ctrl`

## Requirements
- R1: `ready` rises on the STABLE_CYC-th consecutive clock edge that samples `uv_ok_h` high. A single edge that samples it low restarts the count.
- R2: `ready` clears on the first clock edge that samples `uv_ok_h` low.
- R3: `gate_h_en` sets on the (HGATE_DLY+1)-th consecutive edge that samples `ready` high. It clears on the first edge that samples `ready` low.
- R4: The request input and the comparator flag each pass through a two-stage synchroniser. The controller acts on a change on the third clock edge after the input changes.
- R5: In time mode (VOLT_MODE=0), a rising request edge sets `gate_l_en` first. `gate_m_en` sets UP_DLY edges later.
- R6: In time mode, a falling request edge clears `gate_m_en` first. `gate_l_en` clears DN_DLY edges later.
- R7: In voltage mode (VOLT_MODE=1), a rising request edge sets `gate_l_en`. `gate_m_en` stays off until the synchronised `fb_above_ref` is high, and sets on the third edge after it rises.
- R8: In voltage mode, a falling request edge clears `gate_m_en` at once. `gate_l_en` clears DN_DLY edges later.
- R9: Only the request input chosen by VOLT_MODE is acted on. The other input has no effect on any gate enable.
- R10: If `ready`, `uv_ok_m` or `uv_ok_l` is sampled low, both `gate_m_en` and `gate_l_en` clear on the next edge. They stay off, even while the request stays high, until a new rising request edge arrives.
- R11: A falling request edge while the up-delay or comparator wait is pending cancels the mid-rail turn-on. `gate_m_en` stays off, and `gate_l_en` clears DN_DLY edges after the falling edge is acted on.
- R12: `gate_m_en` is never high while `gate_l_en` is low.
- R13: A rising request edge while `ready` is low leaves `gate_l_en` and `gate_m_en` off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uv_ok_h | input | 1 | High rail above undervoltage threshold |
| uv_ok_m | input | 1 | Mid rail above undervoltage threshold |
| uv_ok_l | input | 1 | Low rail above undervoltage threshold |
| seq_time | input | 1 | Time-mode sequence request, edge-acted |
| seq_volt | input | 1 | Voltage-mode sequence request, edge-acted |
| fb_above_ref | input | 1 | Low-rail feedback above reference |
| ready | output | 1 | High rail stable |
| gate_h_en | output | 1 | High-rail gate enable |
| gate_m_en | output | 1 | Mid-rail gate enable |
| gate_l_en | output | 1 | Low-rail gate enable |

## Verification
READY is due STABLE_CYC edges after `uv_ok_h` rises and clears one edge after it falls. The high gate enable lags READY by HGATE_DLY+1 edges. A request or comparator change reaches the gate enables on the third edge. The mid enable then lags by UP_DLY edges, and the low enable's turn-off lags the mid by DN_DLY edges. Inputs are driven at the falling clock edge, and the bench advances an exact number of rising edges before sampling at the next falling edge. For every timed step it checks the cycle just before the output is due and the cycle on which it is due. Two instances, one per mode, share the same stimulus, so each one's indifference to the other request input is observed at its outputs.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_UP   = 2'd1,
    ST_ON   = 2'd2,
    ST_DOWN = 2'd3
  } seq_state_t;
endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else if (i == 0) chain[i] <= d;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ready_timer.sv
module ready_timer #(
  parameter int STABLE_CYC = 1000,
  parameter int HGATE_DLY  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic uv_ok_h,
  output logic ready,
  output logic gate_h_en
);
  localparam int SW = $clog2(STABLE_CYC + 1);
  localparam int HW = $clog2(HGATE_DLY + 2);

  logic [SW-1:0] stab_cnt;
  logic [HW-1:0] hdly_cnt;

  // stability timer: saturates at STABLE_CYC, restarts on any low sample
  always_ff @(posedge clk) begin
    if (rst || !uv_ok_h) begin
      stab_cnt <= '0;
      ready    <= 1'b0;
    end else if (stab_cnt != SW'(STABLE_CYC)) begin
      stab_cnt <= stab_cnt + 1'b1;
      ready    <= (stab_cnt == SW'(STABLE_CYC - 1));
    end else begin
      ready <= 1'b1;
    end
  end

  // high-rail gate turn-on delay, immediate turn-off
  always_ff @(posedge clk) begin
    if (rst || !ready) begin
      hdly_cnt  <= '0;
      gate_h_en <= 1'b0;
    end else if (hdly_cnt == HW'(HGATE_DLY)) begin
      gate_h_en <= 1'b1;
    end else begin
      hdly_cnt <= hdly_cnt + 1'b1;
    end
  end

  a_r2_ready_drop: assert property (@(posedge clk) disable iff (rst)
    !uv_ok_h |=> !ready);
  a_r1_ready_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(uv_ok_h));
  a_r3_gate_h_off: assert property (@(posedge clk) disable iff (rst)
    !ready |=> !gate_h_en);
  a_r3_gate_h_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_h_en) |-> $past(ready));
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import rail_seq_pkg::*;
#(
  parameter bit VOLT_MODE = 1'b0,
  parameter int UP_DLY    = 100,
  parameter int DN_DLY    = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic rails_ok,
  input  logic req_s,
  input  logic fb_s,
  output logic gate_m_en,
  output logic gate_l_en
);
  localparam int MAXD = (UP_DLY > DN_DLY) ? UP_DLY : DN_DLY;
  localparam int CW   = $clog2(MAXD + 1);

  seq_state_t    state, nxt;
  logic [CW-1:0] cnt, cnt_nxt;
  logic          req_q, req_rise, req_fall, mid_go;

  assign req_rise = req_s && !req_q;
  assign req_fall = !req_s && req_q;

  generate
    if (VOLT_MODE) begin : g_volt
      assign mid_go = fb_s;
    end else begin : g_time
      assign mid_go = (cnt == CW'(UP_DLY - 1));
    end
  endgenerate

  always_comb begin
    nxt     = state;
    cnt_nxt = cnt + 1'b1;
    if (!rails_ok) begin
      nxt     = ST_IDLE;
      cnt_nxt = '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          cnt_nxt = '0;
          if (req_rise) nxt = ST_UP;
        end
        ST_UP: begin
          if (req_fall) begin
            nxt = ST_DOWN; cnt_nxt = '0;
          end else if (mid_go) begin
            nxt = ST_ON; cnt_nxt = '0;
          end
        end
        ST_ON: begin
          cnt_nxt = '0;
          if (req_fall) nxt = ST_DOWN;
        end
        ST_DOWN: begin
          if (req_rise) begin
            nxt = ST_UP; cnt_nxt = '0;
          end else if (cnt == CW'(DN_DLY - 1)) begin
            nxt = ST_IDLE; cnt_nxt = '0;
          end
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      req_q     <= 1'b0;
      gate_m_en <= 1'b0;
      gate_l_en <= 1'b0;
    end else begin
      state     <= nxt;
      cnt       <= cnt_nxt;
      req_q     <= req_s;
      gate_m_en <= (nxt == ST_ON);
      gate_l_en <= (nxt != ST_IDLE);
    end
  end

  a_r12_mid_needs_low: assert property (@(posedge clk) disable iff (rst)
    gate_m_en |-> gate_l_en);
  a_r10_fault_all_off: assert property (@(posedge clk) disable iff (rst)
    !rails_ok |=> (!gate_m_en && !gate_l_en));
  a_r13_on_needs_ready: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_l_en) |-> $past(rails_ok));
  a_r6_mid_off_first: assert property (@(posedge clk) disable iff (rst)
    ($fell(gate_l_en) && $past(rails_ok)) |-> !$past(gate_m_en));
  a_r5_mid_after_low: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_m_en) |-> $past(gate_l_en));
endmodule

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl #(
  parameter bit VOLT_MODE  = 1'b0,
  parameter int STABLE_CYC = 1000,
  parameter int HGATE_DLY  = 8,
  parameter int UP_DLY     = 100,
  parameter int DN_DLY     = 100,
  parameter int SYNC_STG   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic uv_ok_h,
  input  logic uv_ok_m,
  input  logic uv_ok_l,
  input  logic seq_time,
  input  logic seq_volt,
  input  logic fb_above_ref,
  output logic ready,
  output logic gate_h_en,
  output logic gate_m_en,
  output logic gate_l_en
);
  logic req_raw, req_s, fb_s, rails_ok;

  assign req_raw  = VOLT_MODE ? seq_volt : seq_time;
  assign rails_ok = ready && uv_ok_m && uv_ok_l;

  ready_timer #(.STABLE_CYC(STABLE_CYC), .HGATE_DLY(HGATE_DLY)) u_rdy (
    .clk(clk), .rst(rst), .uv_ok_h(uv_ok_h),
    .ready(ready), .gate_h_en(gate_h_en));

  bit_sync #(.STAGES(SYNC_STG)) u_req_sync (
    .clk(clk), .rst(rst), .d(req_raw), .q(req_s));

  bit_sync #(.STAGES(SYNC_STG)) u_fb_sync (
    .clk(clk), .rst(rst), .d(fb_above_ref), .q(fb_s));

  seq_fsm #(.VOLT_MODE(VOLT_MODE), .UP_DLY(UP_DLY), .DN_DLY(DN_DLY)) u_fsm (
    .clk(clk), .rst(rst), .rails_ok(rails_ok), .req_s(req_s), .fb_s(fb_s),
    .gate_m_en(gate_m_en), .gate_l_en(gate_l_en));
endmodule

// File: tb/sim_rail_seq_ctrl.sv
module sim_rail_seq_ctrl;
  localparam int S  = 6;
  localparam int HD = 3;
  localparam int UP = 5;
  localparam int DN = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic uv_h = 1'b0, uv_m = 1'b1, uv_l = 1'b1;
  logic sq_t = 1'b0, sq_v = 1'b0, fb = 1'b0;
  logic rdy0, gh0, gm0, gl0, rdy1, gh1, gm1, gl1;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  rail_seq_ctrl #(.VOLT_MODE(1'b0), .STABLE_CYC(S), .HGATE_DLY(HD),
    .UP_DLY(UP), .DN_DLY(DN)) u0 (
    .clk(clk), .rst(rst), .uv_ok_h(uv_h), .uv_ok_m(uv_m), .uv_ok_l(uv_l),
    .seq_time(sq_t), .seq_volt(sq_v), .fb_above_ref(fb),
    .ready(rdy0), .gate_h_en(gh0), .gate_m_en(gm0), .gate_l_en(gl0));

  rail_seq_ctrl #(.VOLT_MODE(1'b1), .STABLE_CYC(S), .HGATE_DLY(HD),
    .UP_DLY(UP), .DN_DLY(DN)) u1 (
    .clk(clk), .rst(rst), .uv_ok_h(uv_h), .uv_ok_m(uv_m), .uv_ok_l(uv_l),
    .seq_time(sq_t), .seq_volt(sq_v), .fb_above_ref(fb),
    .ready(rdy1), .gate_h_en(gh1), .gate_m_en(gm1), .gate_l_en(gl1));

  // {high-cycles[7:1], expected ready[0]}
  localparam logic [7:0] RDY_TAB [5] = '{
    {7'(S-1), 1'b0}, {7'(S), 1'b1}, {7'd1, 1'b0}, {7'(S+3), 1'b1}, {7'(S-2), 1'b0}
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    tick(3);
    chk("reset ready", rdy0, 1'b0);
    chk("reset gate_h", gh0, 1'b0);
    chk("reset gate_l", gl0, 1'b0);
    chk("reset gate_m", gm1, 1'b0);
    rst = 1'b0;

    // R1/R2 table walk
    for (int i = 0; i < 5; i++) begin
      uv_h = 1'b1;
      tick(int'(RDY_TAB[i][7:1]));
      chk("R1 ready after run", rdy0, RDY_TAB[i][0]);
      uv_h = 1'b0;
      tick(1);
      chk("R2 ready drop", rdy0, 1'b0);
    end

    // R3 high gate delay
    uv_h = 1'b1;
    tick(S);
    chk("R1 ready due", rdy0, 1'b1);
    tick(HD);
    chk("R3 gate_h not yet", gh0, 1'b0);
    tick(1);
    chk("R3 gate_h due", gh0, 1'b1);

    // R4/R5 time-mode power-up
    sq_t = 1'b1;
    tick(2);
    chk("R4 gate_l before sync", gl0, 1'b0);
    tick(1);
    chk("R5 gate_l on", gl0, 1'b1);
    chk("R5 gate_m waits", gm0, 1'b0);
    tick(UP - 1);
    chk("R5 gate_m not yet", gm0, 1'b0);
    tick(1);
    chk("R5 gate_m on", gm0, 1'b1);
    chk("R9 volt unit ignores seq_time", gl1, 1'b0);

    // R6 time-mode power-down
    sq_t = 1'b0;
    tick(2);
    chk("R6 gate_m still on", gm0, 1'b1);
    tick(1);
    chk("R6 gate_m off", gm0, 1'b0);
    chk("R6 gate_l held", gl0, 1'b1);
    tick(DN - 1);
    chk("R6 gate_l not yet", gl0, 1'b1);
    tick(1);
    chk("R6 gate_l off", gl0, 1'b0);

    // R7 voltage mode
    sq_v = 1'b1;
    tick(3);
    chk("R7 gate_l on", gl1, 1'b1);
    tick(10);
    chk("R7 gate_m waits comparator", gm1, 1'b0);
    chk("R9 time unit ignores seq_volt", gl0, 1'b0);
    fb = 1'b1;
    tick(2);
    chk("R7 gate_m before sync", gm1, 1'b0);
    tick(1);
    chk("R7 gate_m on", gm1, 1'b1);

    // R8 voltage-mode power-down
    sq_v = 1'b0;
    tick(3);
    chk("R8 gate_m off", gm1, 1'b0);
    chk("R8 gate_l held", gl1, 1'b1);
    tick(DN - 1);
    chk("R8 gate_l not yet", gl1, 1'b1);
    tick(1);
    chk("R8 gate_l off", gl1, 1'b0);
    fb = 1'b0;

    // R11 cancel during up-delay
    sq_t = 1'b1;
    tick(3);
    chk("R11 gate_l on", gl0, 1'b1);
    tick(1);
    sq_t = 1'b0;
    tick(3);
    chk("R11 gate_m cancelled", gm0, 1'b0);
    chk("R11 gate_l held", gl0, 1'b1);
    tick(DN - 1);
    chk("R11 gate_m stays off past up-delay", gm0, 1'b0);
    chk("R11 gate_l not yet", gl0, 1'b1);
    tick(1);
    chk("R11 gate_l off", gl0, 1'b0);

    // R10 fault and fresh-edge requirement
    sq_t = 1'b1;
    tick(3 + UP);
    chk("R10 precondition gate_m on", gm0, 1'b1);
    uv_m = 1'b0;
    tick(1);
    chk("R10 gate_m off on fault", gm0, 1'b0);
    chk("R10 gate_l off on fault", gl0, 1'b0);
    uv_m = 1'b1;
    tick(8);
    chk("R10 stays off without new edge", gl0, 1'b0);
    sq_t = 1'b0;
    tick(4);

    // R13 no start while not ready
    uv_h = 1'b0;
    tick(1);
    chk("R2 ready drop before R13", rdy0, 1'b0);
    chk("R3 gate_h off", gh0, 1'b1);
    tick(1);
    chk("R3 gate_h off after ready", gh0, 1'b0);
    sq_t = 1'b1;
    tick(6);
    chk("R13 gate_l stays off", gl0, 1'b0);
    chk("R12 gate_m stays off", gm0, 1'b0);
    sq_t = 1'b0;
    tick(2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule